// File: doc/BRIEF.md
# Glide-Capable Bias Code Sequencer

This block produces the 7-bit code for one bias channel of a tunable-capacitor controller. A new destination code comes in with a one-cycle load strobe. How the output reaches that destination depends on the mode bits that come with it. In the direct modes the output takes the new code on the next clock. The turbo bit only adds a drive-strength hint for the analog stage that follows. In glide mode the code moves from its present value to the destination in exactly 256 evenly timed sub-steps, so the tuned capacitance changes without a phase jump. The spacing between sub-steps is set by a step-delay field and counted in microsecond ticks.

An external swap event can interrupt a glide. It moves the output straight to the code presented with it, which supports antenna or register switching. A destination code of zero means the output must be released rather than driven to 0 V, and the block reports this on a separate flag.

Top module: `glide_dac_seq`

## Requirements
- R1: Out of reset `codeOut` is 0, `hiZ` is 1, and `busy` and `turboDrive` are both 0.
- R2: A load with `glideEn`=0 sets `codeOut` to `targetCode` on the clock edge that samples the load. `busy` stays 0.
- R3: A direct load copies `turboBit` into `turboDrive`. A glide load ignores `turboBit` and clears `turboDrive`.
- R4: After a glide load from code S to code T, the code after step k (k = 1..256) is floor((256*S + k*(T-S))/256). Step 256 lands exactly on T. `busy` is 1 from the load edge until the edge of step 256, where it returns to 0.
- R5: The steps of a glide are P = 2 + `stepDelay` microsecond ticks apart. `stepDelay` is 6 bits, so a full glide takes 512 to 16640 ticks. Step k happens on the edge of tick k*P counted after the load. The value of `stepDelay` is captured at the load, and later changes do not affect the running glide.
- R6: While `usTick` is low, a glide holds its code and its position in the step timing.
- R7: A `swapPulse` sets `codeOut` to `targetCode` on the next edge, aborts any glide (`busy` becomes 0) and copies `turboBit` into `turboDrive`. It takes priority over a load in the same cycle.
- R8: A load that arrives during a glide starts a new 256-step glide. The new glide starts from the integer code present at that moment.
- R9: `hiZ` is 1 exactly when the destination code of the latest load or swap is 0, and it changes on the same edge. It does not follow the intermediate codes of a glide.
- R10: Each glide step moves the code toward the destination or leaves it unchanged, never away from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| targetCode | input | 7 | Destination code for a load or swap |
| targetLoad | input | 1 | One-cycle strobe to accept a new destination |
| glideEn | input | 1 | Selects glide mode for the load |
| turboBit | input | 1 | Turbo request for direct loads and swaps |
| stepDelay | input | 6 | Step spacing field: P = 2 + value, in microsecond ticks |
| swapPulse | input | 1 | Swap event: jump at once, abort any glide |
| usTick | input | 1 | One-cycle pulse every microsecond |
| codeOut | output | 7 | Current channel code |
| hiZ | output | 1 | Output released (destination code is zero) |
| busy | output | 1 | Glide in progress |
| turboDrive | output | 1 | Turbo drive hint for the analog stage |

## Verification
Random glides between random codes, in both directions and with several step spacings, are compared every cycle against the closed-form step formula. These runs separate correct fixed-point accumulation from rounding drift, and correct tick pacing from off-by-one timing. Directed runs cover the extremes of the spacing, a change to the delay field during a glide, a stalled tick, a restart in mid-glide and a swap in mid-glide. Each of these shows whether the step timing, the start point and the abort path are held correctly. Random direct and turbo loads, together with glides to and from code zero, separate the turbo hint and the release flag from the code path.

// File: rtl/glide_seq_pkg.sv
`timescale 1ns/1ps
package glide_seq_pkg;
  // Strobes from the sequencing control to the code datapath
  typedef struct packed {
    logic jumpNow;     // take the target code at once
    logic glideStart;  // begin a glide from the current integer code
    logic stepNow;     // apply one glide increment
    logic lastStep;    // this increment is the final one
  } seqStrobes_t;
endpackage

// File: rtl/glide_seq_ctrl.sv
`timescale 1ns/1ps
module glide_seq_ctrl
  import glide_seq_pkg::*;
#(
  parameter int DELAY_W  = 6,
  parameter int STEP_MIN = 2,
  parameter int FRAC_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadReq,
  input  logic               swapReq,
  input  logic               glideEn,
  input  logic               turboBit,
  input  logic               usTick,
  input  logic [DELAY_W-1:0] stepDelay,
  output seqStrobes_t        strobes,
  output logic               busy,
  output logic               turboDrive
);
  localparam int PER_MAX = STEP_MIN + (1 << DELAY_W) - 1;
  localparam int PER_W   = $clog2(PER_MAX + 1);

  logic [PER_W-1:0]  periodQ;
  logic [PER_W-1:0]  tickCnt;
  logic [FRAC_W-1:0] stepCnt;
  logic              busyQ;
  logic              turboQ;

  logic directHit, glideHit, stepFire, lastFire, tickDone;

  always_comb begin
    directHit = swapReq | (loadReq & ~glideEn);
    glideHit  = ~swapReq & loadReq & glideEn;
    tickDone  = (tickCnt == periodQ - PER_W'(1));
    stepFire  = busyQ & usTick & tickDone & ~swapReq & ~loadReq;
    lastFire  = stepFire & (stepCnt == {FRAC_W{1'b1}});
    strobes.jumpNow    = directHit;
    strobes.glideStart = glideHit;
    strobes.stepNow    = stepFire;
    strobes.lastStep   = lastFire;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodQ <= PER_W'(STEP_MIN);
      tickCnt <= '0;
      stepCnt <= '0;
      busyQ   <= 1'b0;
      turboQ  <= 1'b0;
    end else if (directHit) begin
      busyQ   <= 1'b0;
      turboQ  <= turboBit;
      tickCnt <= '0;
      stepCnt <= '0;
    end else if (glideHit) begin
      busyQ   <= 1'b1;
      turboQ  <= 1'b0;
      tickCnt <= '0;
      stepCnt <= '0;
      periodQ <= PER_W'(STEP_MIN) + PER_W'(stepDelay);
    end else if (busyQ && usTick) begin
      if (tickDone) begin
        tickCnt <= '0;
        stepCnt <= stepCnt + FRAC_W'(1);
        if (lastFire) busyQ <= 1'b0;
      end else begin
        tickCnt <= tickCnt + PER_W'(1);
      end
    end
  end

  assign busy       = busyQ;
  assign turboDrive = turboQ;

  AST_STEP_GAP: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stepNow |=> !strobes.stepNow); // R5
  AST_SWAP_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    swapReq |=> !busyQ); // R7
  AST_GLIDE_NO_TURBO: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> !turboQ); // R3
  AST_STEP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !usTick && !loadReq && !swapReq) |=> $stable(stepCnt)); // R6
endmodule

// File: rtl/glide_seq_datapath.sv
`timescale 1ns/1ps
module glide_seq_datapath
  import glide_seq_pkg::*;
#(
  parameter int CODE_W = 7,
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic [CODE_W-1:0] targetIn,
  output logic [CODE_W-1:0] codeOut,
  output logic              hiZ
);
  localparam int ACC_W = CODE_W + FRAC_W;
  localparam int DLT_W = CODE_W + 1;
  localparam int EXT_W = ACC_W - DLT_W;

  logic [ACC_W-1:0]  accQ;
  logic [DLT_W-1:0]  deltaQ;   // two's complement per-step increment in 1/2^FRAC_W
  logic [CODE_W-1:0] destQ;
  logic [CODE_W-1:0] curInt;
  logic [ACC_W-1:0]  deltaExt;
  logic [DLT_W-1:0]  newDelta;

  always_comb begin
    curInt   = accQ[ACC_W-1:FRAC_W];
    deltaExt = {{EXT_W{deltaQ[DLT_W-1]}}, deltaQ};
    newDelta = {1'b0, targetIn} - {1'b0, curInt};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ   <= '0;
      deltaQ <= '0;
      destQ  <= '0;
    end else if (strobes.jumpNow) begin
      accQ   <= {targetIn, {FRAC_W{1'b0}}};
      deltaQ <= '0;
      destQ  <= targetIn;
    end else if (strobes.glideStart) begin
      accQ   <= {curInt, {FRAC_W{1'b0}}};
      deltaQ <= newDelta;
      destQ  <= targetIn;
    end else if (strobes.stepNow) begin
      accQ   <= accQ + deltaExt;
    end
  end

  assign codeOut = curInt;
  assign hiZ     = (destQ == '0);

  AST_JUMP_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.jumpNow |=> codeOut == $past(targetIn)); // R2
  AST_GLIDE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.lastStep |=> codeOut == $past(destQ)); // R4
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stepNow && !deltaQ[DLT_W-1]) |=>
      (codeOut >= $past(codeOut) && codeOut <= destQ)); // R10
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stepNow && deltaQ[DLT_W-1]) |=>
      (codeOut <= $past(codeOut) && codeOut >= destQ)); // R10
endmodule

// File: rtl/glide_dac_seq.sv
`timescale 1ns/1ps
module glide_dac_seq
  import glide_seq_pkg::*;
#(
  parameter int CODE_W   = 7,
  parameter int DELAY_W  = 6,
  parameter int FRAC_W   = 8,
  parameter int STEP_MIN = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CODE_W-1:0]  targetCode,
  input  logic               targetLoad,
  input  logic               glideEn,
  input  logic               turboBit,
  input  logic [DELAY_W-1:0] stepDelay,
  input  logic               swapPulse,
  input  logic               usTick,
  output logic [CODE_W-1:0]  codeOut,
  output logic               hiZ,
  output logic               busy,
  output logic               turboDrive
);
  seqStrobes_t strobes;

  glide_seq_ctrl #(
    .DELAY_W (DELAY_W),
    .STEP_MIN(STEP_MIN),
    .FRAC_W  (FRAC_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .loadReq   (targetLoad),
    .swapReq   (swapPulse),
    .glideEn   (glideEn),
    .turboBit  (turboBit),
    .usTick    (usTick),
    .stepDelay (stepDelay),
    .strobes   (strobes),
    .busy      (busy),
    .turboDrive(turboDrive)
  );

  glide_seq_datapath #(
    .CODE_W(CODE_W),
    .FRAC_W(FRAC_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .targetIn(targetCode),
    .codeOut (codeOut),
    .hiZ     (hiZ)
  );

  AST_HIZ_FOLLOWS_DEST: assert property (@(posedge clk) disable iff (!rstN)
    (targetLoad || swapPulse) |=> hiZ == ($past(targetCode) == '0)); // R9
endmodule

// File: tb/glide_dac_seq_bench.sv
`timescale 1ns/1ps
module glide_dac_seq_bench;
  logic       clk = 1'b0;
  logic       rstN;
  logic [6:0] targetCode;
  logic       targetLoad, glideEn, turboBit, swapPulse, usTick;
  logic [5:0] stepDelay;
  logic [6:0] codeOut;
  logic       hiZ, busy, turboDrive;

  int checks = 0;
  int errors = 0;
  int curCode = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  glide_dac_seq u_glide_dac_seq (
    .clk(clk), .rstN(rstN), .targetCode(targetCode), .targetLoad(targetLoad),
    .glideEn(glideEn), .turboBit(turboBit), .stepDelay(stepDelay),
    .swapPulse(swapPulse), .usTick(usTick), .codeOut(codeOut), .hiZ(hiZ),
    .busy(busy), .turboDrive(turboDrive)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int expCode(input int s, input int t, input int k);
    int kk;
    kk = (k > 256) ? 256 : k;
    return (s * 256 + kk * (t - s)) / 256;
  endfunction

  // Called at a negedge; returns at the negedge after the sampling edge.
  task automatic loadTgt(input int t, input bit g, input bit tb, input int dly);
    targetCode = 7'(t); glideEn = g; turboBit = tb; stepDelay = 6'(dly);
    targetLoad = 1'b1;
    @(negedge clk);
    targetLoad = 1'b0;
  endtask

  task automatic directLoad(input int t, input bit tb, input string req);
    loadTgt(t, 1'b0, tb, 0);
    curCode = t;
    chk(codeOut == 7'(t), req, codeOut, t);
    chk(turboDrive == tb, req, turboDrive, tb);
    chk(busy == 1'b0, req, busy, 0);
    chk(hiZ == (t == 0), req, hiZ, t == 0);
  endtask

  task automatic glideRun(input int t, input int dly, input bit tb, input int cycles,
                          input string req);
    int s, p, e;
    s = curCode;
    p = 2 + dly;
    loadTgt(t, 1'b1, tb, dly);
    stepDelay = ~6'(dly);  // must not affect the running glide (R5)
    chk(codeOut == 7'(s), req, codeOut, s);
    chk(busy == 1'b1, req, busy, 1);
    chk(turboDrive == 1'b0, "R3", turboDrive, 0);
    chk(hiZ == (t == 0), "R9", hiZ, t == 0);
    for (int c = 1; c <= cycles; c++) begin
      @(negedge clk);
      e = expCode(s, t, c / p);
      chk(codeOut == 7'(e), req, codeOut, e);
      chk(busy == (c < 256 * p), "R5", busy, c < 256 * p);
    end
    curCode = expCode(s, t, cycles / p);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    int p, hold;
    seed = $urandom(32'h00C0FFEE);
    rstN = 1'b0; targetCode = '0; targetLoad = 0; glideEn = 0; turboBit = 0;
    stepDelay = '0; swapPulse = 0; usTick = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(codeOut == 0, "R1", codeOut, 0);
    chk(hiZ == 1, "R1", hiZ, 1);
    chk(busy == 0, "R1", busy, 0);
    chk(turboDrive == 0, "R1", turboDrive, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 normal, R3 turbo
    directLoad(64, 1'b0, "R2");
    directLoad(17, 1'b1, "R3");
    glideRun(100, 0, 1'b1, 256 * 2 + 2, "R4");
    chk(codeOut == 100, "R4", codeOut, 100);

    // R9: direct load of zero, glide out of zero and back into zero
    directLoad(0, 1'b0, "R9");
    glideRun(50, 1, 1'b0, 256 * 3 + 1, "R9");
    glideRun(0, 0, 1'b0, 10, "R9");
    chk(hiZ == 1 && codeOut != 0, "R9", hiZ, 1);
    glideRun(0, 0, 1'b0, 520, "R9");

    // R5: slowest spacing with the delay field changed mid-glide
    directLoad(3, 1'b0, "R2");
    glideRun(120, 63, 1'b0, 256 * 65 + 2, "R5");

    // R6: tick stall
    directLoad(10, 1'b0, "R2");
    loadTgt(110, 1'b1, 1'b0, 2);
    usTick = 1'b0;
    repeat (40) begin
      @(negedge clk);
      chk(codeOut == 10 && busy == 1, "R6", codeOut, 10);
    end
    usTick = 1'b1;
    repeat (256 * 4 - 1) @(negedge clk);
    chk(busy == 1, "R6", busy, 1);
    @(negedge clk);
    chk(busy == 0 && codeOut == 110, "R6", codeOut, 110);
    curCode = 110;

    // R8: restart mid-glide from the current integer code
    directLoad(20, 1'b0, "R2");
    glideRun(120, 0, 1'b0, 300, "R8");
    chk(curCode == 78, "R8", curCode, 78);
    glideRun(5, 1, 1'b0, 256 * 3 + 1, "R8");

    // R7: swap aborts a glide
    directLoad(0, 1'b0, "R2");
    glideRun(127, 0, 1'b0, 100, "R7");
    targetCode = 7'd33; turboBit = 1'b1; glideEn = 1'b1; swapPulse = 1'b1;
    @(negedge clk);
    swapPulse = 1'b0;
    chk(codeOut == 33, "R7", codeOut, 33);
    chk(busy == 0, "R7", busy, 0);
    chk(turboDrive == 1, "R7", turboDrive, 1);
    repeat (20) @(negedge clk);
    chk(codeOut == 33, "R7", codeOut, 33);
    // R7: swap wins over a simultaneous glide load
    targetCode = 7'd90; turboBit = 1'b0; glideEn = 1'b1;
    swapPulse = 1'b1; targetLoad = 1'b1;
    @(negedge clk);
    swapPulse = 1'b0; targetLoad = 1'b0;
    chk(codeOut == 90 && busy == 0, "R7", codeOut, 90);
    curCode = 90;

    // Random direct / turbo loads (R2, R3)
    for (int i = 0; i < 12; i++) begin
      directLoad(int'($urandom_range(0, 127)), 1'($urandom_range(0, 1)), "R3");
    end

    // Random full glides, both directions (R4, R10)
    for (int i = 0; i < 6; i++) begin
      p = int'($urandom_range(0, 3));
      hold = int'($urandom_range(0, 127));
      glideRun(hold, p, 1'($urandom_range(0, 1)), 256 * (p + 2) + 2, "R10");
      chk(codeOut == 7'(hold), "R4", codeOut, hold);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule